// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a virtual address into a real memory address by walking two tables that sit in memory. The first read fetches a segment table word, which points at a page table. The second read fetches a page table word, which holds the real frame number. The low 12 bits of the virtual address are the byte offset and pass through unchanged. Each request chooses one of two address formats. The narrow format uses 24 bits with a 4-bit segment index. The wide format uses all 32 bits with a 12-bit segment index. In both formats the page index is 8 bits and the offset is 12 bits.

A request either returns a real address or stops with an exception code. Code 16 means the segment translation failed and code 17 means the page translation failed. Each real frame has a reference bit and a change bit, kept in a small internal array. A successful access updates these bits. A translate-only (probe) request returns the same result but leaves the bits alone. Software reads the bits through a select input and can clear the bits of one frame with a strobe. A disable input switches translation off, and the real address is then the low bits of the virtual address.

Table words are fetched over a memory read port that allows only one read at a time. Its latency is arbitrary: a read ends when the memory raises its acknowledge.

Top module: `xlate_walk_top`

## Requirements
- R1: In narrow mode (`req_wide`=0) the segment index is va[23:20], the page index is va[19:12] and the offset is va[11:0]. Bits va[31:24] have no effect.
- R2: In wide mode (`req_wide`=1) the segment index is va[31:20]. The page index and the offset are the same fields as in R1.
- R3: The segment word is read at `ctl_sto` + 4 × segment index. Its bits [15:2], with the two low bits zero, give the page table origin. The page word is read at that origin + 4 × page index. The real address is {page word[15:12], offset}. All addresses are 16 bits wide and wrap on overflow.
- R4: A segment index greater than `ctl_stl` ends the request with `rsp_fault`=1 and code 16. No memory read is made, and the response comes in the cycle after the request is accepted.
- R5: A segment word with bit 0 set ends the request with code 16, and no page word is read.
- R6: A page word with bit 0 set ends the request with code 17.
- R7: A successful request that is not a probe sets the reference bit of its frame. If it is a write (`req_write`=1), it also sets the change bit.
- R8: A probe (`req_probe`=1) returns the same address or code as a normal request and does not change any reference or change bit.
- R9: A faulting request does not change any reference or change bit. A faulting response reports `rsp_addr`=0.
- R10: `rc_clr` clears both bits of frame `rc_sel`. If a set lands on the same frame in the same cycle, the clear is applied first and the set second. `rc_ref` and `rc_chg` always show the bits of frame `rc_sel`.
- R11: With `ctl_xoff`=1 the response comes in the cycle after acceptance. It carries `rsp_addr`=va[15:0] and no fault, makes no memory read, and updates bits per R7 for frame va[15:12].
- R12: `mem_rd` stays high with a stable `mem_addr` until `mem_ack`. `req_ready` is low from acceptance until the response. `rsp_valid` lasts exactly one cycle.
- R13: After reset: `req_ready`=1, `rsp_valid`=0, `mem_rd`=0, and every reference and change bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is high |
| req_ready | output | 1 | Translator idle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_wide | input | 1 | 1 = 32-bit format, 0 = 24-bit format |
| req_probe | input | 1 | Translate only, no bit upkeep |
| ctl_sto | input | 16 | Segment table origin |
| ctl_stl | input | 12 | Highest valid segment index |
| ctl_xoff | input | 1 | Translation disabled |
| mem_rd | output | 1 | Table word read request |
| mem_addr | output | 16 | Table word byte address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 32 | Table word |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Result is an exception |
| rsp_code | output | 5 | Exception code (16 or 17), else 0 |
| rsp_addr | output | 16 | Real address |
| rc_sel | input | 4 | Frame to read or clear |
| rc_clr | input | 1 | Clear strobe for frame `rc_sel` |
| rc_ref | output | 1 | Reference bit of `rc_sel` |
| rc_chg | output | 1 | Change bit of `rc_sel` |

## Verification
The hardest case to reach from the ports is a software clear and a bit update hitting the same frame in the same clock edge. During a table walk, that edge depends on the memory latency. The stimulus avoids this by switching translation off. The update then happens on the acceptance edge itself, so the clear strobe and the request can be driven in the same cycle on a frame whose change bit was set earlier. The result must show the reference bit set and the change bit cleared. The table contents are computed from the address, and sweeps cover every segment and many page indices in both formats, with invalid entries placed throughout.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [1:0] {
      W_IDLE = 2'd0,
      W_SEG  = 2'd1,
      W_PAG  = 2'd2,
      W_RESP = 2'd3
   } walk_st_t;

   localparam int CODE_W = 5;
   localparam logic [CODE_W-1:0] XC_NONE = 5'd0;
   localparam logic [CODE_W-1:0] XC_SEG  = 5'd16;
   localparam logic [CODE_W-1:0] XC_PAG  = 5'd17;
endpackage

// File: rtl/xlate_split.sv
module xlate_split #(
   parameter int VA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int PIX_W  = 8,
   parameter int SIXN_W = 4,
   parameter int SIXW_W = 12
) (
   input  logic [VA_W-1:0]   va,
   input  logic              wide,
   output logic [SIXW_W-1:0] six,
   output logic [PIX_W-1:0]  pix,
   output logic [OFF_W-1:0]  off
);
   localparam int SIX_LSB = OFF_W + PIX_W;

   assign off = va[OFF_W-1:0];
   assign pix = va[SIX_LSB-1:OFF_W];

   generate
      if (SIXN_W == SIXW_W) begin : g_one
         logic unused_wide;
         assign unused_wide = wide;
         assign six = va[SIX_LSB +: SIXW_W];
      end else begin : g_two
         logic [SIXW_W-1:0] six_n;
         assign six_n = {{(SIXW_W-SIXN_W){1'b0}}, va[SIX_LSB +: SIXN_W]};
         assign six   = wide ? va[SIX_LSB +: SIXW_W] : six_n;
      end
      if (VA_W > SIX_LSB + SIXW_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^va[VA_W-1:SIX_LSB+SIXW_W];
      end
   endgenerate
endmodule

// File: rtl/xlate_rcbits.sv
module xlate_rcbits #(
   parameter int FN_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [FN_W-1:0] set_fn,
   input  logic            set_chg,
   input  logic            clr_en,
   input  logic [FN_W-1:0] clr_fn,
   input  logic [FN_W-1:0] rd_fn,
   output logic            rd_ref,
   output logic            rd_chg
);
   localparam int NF = 1 << FN_W;

   logic [NF-1:0] ref_q, chg_q, ref_n, chg_n;

   generate
      for (genvar f = 0; f < NF; f++) begin : g_fr
         logic hit_s, hit_c;
         assign hit_s    = set_en && (set_fn == FN_W'(f));
         assign hit_c    = clr_en && (clr_fn == FN_W'(f));
         assign ref_n[f] = (ref_q[f] && !hit_c) || hit_s;
         assign chg_n[f] = (chg_q[f] && !hit_c) || (hit_s && set_chg);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         chg_q <= '0;
      end else begin
         ref_q <= ref_n;
         chg_q <= chg_n;
      end
   end

   assign rd_ref = ref_q[rd_fn];
   assign rd_chg = chg_q[rd_fn];

   // R7
   ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ref_q[$past(set_fn)]);

   // R7
   chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && set_chg) |=> chg_q[$past(set_fn)]);

   // R10
   clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_fn == clr_fn)) |=>
         (!ref_q[$past(clr_fn)] && !chg_q[$past(clr_fn)]));
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
   import xlate_pkg::*;
#(
   parameter int PA_W   = 16,
   parameter int OFF_W  = 12,
   parameter int PIX_W  = 8,
   parameter int SIXW_W = 12,
   parameter int ENT_W  = 32,
   localparam int FN_W  = PA_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PA_W-1:0]   va_lo,
   input  logic [SIXW_W-1:0] six,
   input  logic [PIX_W-1:0]  pix,
   input  logic [OFF_W-1:0]  off,
   input  logic              req_write,
   input  logic              req_probe,
   input  logic [PA_W-1:0]   ctl_sto,
   input  logic [SIXW_W-1:0] ctl_stl,
   input  logic              ctl_xoff,
   output logic              mem_rd,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_ack,
   input  logic [ENT_W-1:0]  mem_data,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [CODE_W-1:0] rsp_code,
   output logic [PA_W-1:0]   rsp_addr,
   output logic              upd_en,
   output logic [FN_W-1:0]   upd_fn,
   output logic              upd_chg
);
   walk_st_t           st;
   logic [PA_W-1:0]    addr_q;
   logic [PIX_W-1:0]   pix_q;
   logic [OFF_W-1:0]   off_q;
   logic               wr_q, probe_q;
   logic               seg_ok, ent_bad;
   logic [PA_W-1:0]    ste_addr, pte_addr;
   logic [FN_W-1:0]    pte_fn;
   logic               unused_ent;

   assign seg_ok   = (six <= ctl_stl);
   assign ent_bad  = mem_data[0];
   assign ste_addr = ctl_sto + (PA_W'(six) << 2);
   assign pte_addr = {mem_data[PA_W-1:2], 2'b00} + (PA_W'(pix_q) << 2);
   assign pte_fn   = mem_data[PA_W-1:OFF_W];
   assign unused_ent = ^{mem_data[ENT_W-1:PA_W], mem_data[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= W_IDLE;
         addr_q    <= '0;
         pix_q     <= '0;
         off_q     <= '0;
         wr_q      <= 1'b0;
         probe_q   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_code  <= XC_NONE;
         rsp_addr  <= '0;
      end else begin
         unique case (st)
            W_IDLE: if (req_valid) begin
               pix_q   <= pix;
               off_q   <= off;
               wr_q    <= req_write;
               probe_q <= req_probe;
               if (ctl_xoff) begin
                  rsp_fault <= 1'b0;
                  rsp_code  <= XC_NONE;
                  rsp_addr  <= va_lo;
                  st        <= W_RESP;
               end else if (!seg_ok) begin
                  rsp_fault <= 1'b1;
                  rsp_code  <= XC_SEG;
                  rsp_addr  <= '0;
                  st        <= W_RESP;
               end else begin
                  addr_q <= ste_addr;
                  st     <= W_SEG;
               end
            end
            W_SEG: if (mem_ack) begin
               if (ent_bad) begin
                  rsp_fault <= 1'b1;
                  rsp_code  <= XC_SEG;
                  rsp_addr  <= '0;
                  st        <= W_RESP;
               end else begin
                  addr_q <= pte_addr;
                  st     <= W_PAG;
               end
            end
            W_PAG: if (mem_ack) begin
               rsp_fault <= ent_bad;
               rsp_code  <= ent_bad ? XC_PAG : XC_NONE;
               rsp_addr  <= ent_bad ? '0 : {pte_fn, off_q};
               st        <= W_RESP;
            end
            W_RESP: st <= W_IDLE;
            default: st <= W_IDLE;
         endcase
      end
   end

   assign req_ready = (st == W_IDLE);
   assign mem_rd    = (st == W_SEG) || (st == W_PAG);
   assign mem_addr  = addr_q;
   assign rsp_valid = (st == W_RESP);

   always_comb begin
      upd_en  = 1'b0;
      upd_fn  = va_lo[PA_W-1:OFF_W];
      upd_chg = req_write;
      if (st == W_IDLE && req_valid && ctl_xoff && !req_probe) begin
         upd_en = 1'b1;
      end else if (st == W_PAG && mem_ack && !ent_bad && !probe_q) begin
         upd_en  = 1'b1;
         upd_fn  = pte_fn;
         upd_chg = wr_q;
      end
   end

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

   // R12
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R4
   stl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !ctl_xoff && (six > ctl_stl)) |=>
         (rsp_valid && rsp_fault && rsp_code == XC_SEG && !mem_rd));

   // R5
   ste_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_SEG && mem_ack && mem_data[0]) |=> (rsp_valid && rsp_code == XC_SEG));

   // R6
   pte_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_PAG && mem_ack && mem_data[0]) |=> (rsp_valid && rsp_code == XC_PAG));

   // R11
   xoff_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && ctl_xoff) |=>
         (rsp_valid && !rsp_fault && rsp_addr == $past(va_lo)));
endmodule

// File: rtl/xlate_walk_top.sv
module xlate_walk_top
   import xlate_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 16,
   parameter int OFF_W  = 12,
   parameter int PIX_W  = 8,
   parameter int SIXN_W = 4,
   parameter int SIXW_W = 12,
   parameter int ENT_W  = 32,
   localparam int FN_W  = PA_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic              req_probe,
   input  logic [PA_W-1:0]   ctl_sto,
   input  logic [SIXW_W-1:0] ctl_stl,
   input  logic              ctl_xoff,
   output logic              mem_rd,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_ack,
   input  logic [ENT_W-1:0]  mem_data,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [CODE_W-1:0] rsp_code,
   output logic [PA_W-1:0]   rsp_addr,
   input  logic [FN_W-1:0]   rc_sel,
   input  logic              rc_clr,
   output logic              rc_ref,
   output logic              rc_chg
);
   generate
      if (OFF_W + PIX_W + SIXW_W > VA_W) begin : g_bad_va
         $error("virtual address too narrow for its fields");
      end
      if (SIXN_W > SIXW_W) begin : g_bad_six
         $error("narrow segment index wider than wide one");
      end
      if (PA_W <= OFF_W || PA_W > ENT_W) begin : g_bad_pa
         $error("real address width out of range");
      end
   endgenerate

   logic [SIXW_W-1:0] six;
   logic [PIX_W-1:0]  pix;
   logic [OFF_W-1:0]  off;
   logic              upd_en, upd_chg;
   logic [FN_W-1:0]   upd_fn;

   xlate_split #(
      .VA_W(VA_W), .OFF_W(OFF_W), .PIX_W(PIX_W), .SIXN_W(SIXN_W), .SIXW_W(SIXW_W)
   ) u_split (
      .va(req_va), .wide(req_wide), .six(six), .pix(pix), .off(off)
   );

   xlate_walk #(
      .PA_W(PA_W), .OFF_W(OFF_W), .PIX_W(PIX_W), .SIXW_W(SIXW_W), .ENT_W(ENT_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .va_lo(req_va[PA_W-1:0]), .six(six), .pix(pix), .off(off),
      .req_write(req_write), .req_probe(req_probe),
      .ctl_sto(ctl_sto), .ctl_stl(ctl_stl), .ctl_xoff(ctl_xoff),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
      .rsp_addr(rsp_addr),
      .upd_en(upd_en), .upd_fn(upd_fn), .upd_chg(upd_chg)
   );

   xlate_rcbits #(.FN_W(FN_W)) u_rc (
      .clk(clk), .rst_n(rst_n),
      .set_en(upd_en), .set_fn(upd_fn), .set_chg(upd_chg),
      .clr_en(rc_clr), .clr_fn(rc_sel), .rd_fn(rc_sel),
      .rd_ref(rc_ref), .rd_chg(rc_chg)
   );

   // R9
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
endmodule

// File: tb/tb_xlate_walk_top.sv
`timescale 1ns/1ps
module tb_xlate_walk_top;
   localparam int STO   = 32'h0400;
   localparam int PTB   = 32'h8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_probe = 1'b0;
   logic [31:0] req_va = '0;
   logic [15:0] ctl_sto = 16'(STO);
   logic [11:0] ctl_stl = 12'd15;
   logic        ctl_xoff = 1'b0;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_data = '0;
   logic [3:0]  rc_sel = '0;
   logic        rc_clr = 1'b0;
   logic        req_ready, mem_rd, rsp_valid, rsp_fault, rc_ref, rc_chg;
   logic [15:0] mem_addr, rsp_addr;
   logic [4:0]  rsp_code;

   int total = 0, bad = 0, nreads = 0;
   logic [15:0] rd_addr [0:3];
   logic exp_ref [0:15];
   logic exp_chg [0:15];

   always #2 clk = ~clk;

   xlate_walk_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_write(req_write), .req_wide(req_wide), .req_probe(req_probe),
      .ctl_sto(ctl_sto), .ctl_stl(ctl_stl), .ctl_xoff(ctl_xoff),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_addr(rsp_addr),
      .rc_sel(rc_sel), .rc_clr(rc_clr), .rc_ref(rc_ref), .rc_chg(rc_chg)
   );

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic ste_bad(input int s);
      return (s % 5) == 3;
   endfunction

   function automatic logic pte_bad(input int k, input int p);
      return ((k * 3 + p) % 7) == 0;
   endfunction

   function automatic logic [31:0] table_word(input logic [15:0] a);
      int ai = int'(a);
      if (ai >= STO && ai < STO + 4 * 4096 && (ai % 4) == 0) begin
         int s = (ai - STO) / 4;
         int pto = PTB + (s % 8) * 32'h400;
         return 32'h5A5A0000 | 32'(pto) | 32'h2 | {31'd0, ste_bad(s)};
      end else if (ai >= PTB && ai < PTB + 8 * 32'h400) begin
         int k = (ai - PTB) / 32'h400;
         int p = ((ai - PTB) / 4) % 256;
         int fn = (k + p) % 16;
         return 32'hC3C30000 | 32'(fn << 12) | 32'h7FE | {31'd0, pte_bad(k, p)};
      end
      return 32'hFFFFFFFF;
   endfunction

   // memory model: arbitrary latency from the address
   initial begin
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_rd) begin
            logic [15:0] a;
            a = mem_addr;
            if (nreads < 4) rd_addr[nreads] = a;
            nreads++;
            repeat ((int'(a) >> 2) % 3) @(negedge clk);
            mem_data = table_word(a);
            mem_ack  = 1'b1;
         end
      end
   end

   task automatic chk_rc(input string req, input int fn);
      rc_sel = 4'(fn);
      #0.5;
      check(req, "ref bit", {31'd0, rc_ref}, {31'd0, exp_ref[fn]});
      check(req, "chg bit", {31'd0, rc_chg}, {31'd0, exp_chg[fn]});
   endtask

   task automatic do_req(input logic [31:0] va, input logic wr, input logic wide,
                         input logic probe);
      logic        e_fault;
      logic [4:0]  e_code;
      logic [15:0] e_addr, a0, a1;
      int          e_reads, s, p, k, fn, waits;
      string       tag;
      s  = wide ? int'(va[31:20]) : int'(va[23:20]);
      p  = int'(va[19:12]);
      k  = s % 8;
      a0 = 16'(STO + 4 * s);
      a1 = 16'(PTB + k * 32'h400 + 4 * p);
      fn = (k + p) % 16;
      e_fault = 1'b0; e_code = 5'd0; e_addr = 16'd0; e_reads = 2;
      tag = wide ? "R2" : "R1";
      if (ctl_xoff) begin
         e_addr = va[15:0]; e_reads = 0; fn = int'(va[15:12]); tag = "R11";
      end else if (s > int'(ctl_stl)) begin
         e_fault = 1'b1; e_code = 5'd16; e_reads = 0; tag = "R4";
      end else if (ste_bad(s)) begin
         e_fault = 1'b1; e_code = 5'd16; e_reads = 1; tag = "R5";
      end else if (pte_bad(k, p)) begin
         e_fault = 1'b1; e_code = 5'd17; tag = "R6";
      end else begin
         e_addr = {4'(fn), va[11:0]};
      end
      @(negedge clk);
      nreads = 0;
      req_va = va; req_write = wr; req_wide = wide; req_probe = probe; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (e_reads > 0) check("R12", "ready while busy", {31'd0, req_ready}, 32'd0);
      waits = 0;
      while (!rsp_valid && waits < 40) begin
         @(negedge clk);
         waits++;
      end
      check(tag, "fault", {31'd0, rsp_fault}, {31'd0, e_fault});
      check(tag, "code", {27'd0, rsp_code}, {27'd0, e_code});
      check(e_fault ? "R9" : "R3", "real addr", {16'd0, rsp_addr}, {16'd0, e_addr});
      check(tag, "read count", nreads, e_reads);
      if (e_reads > 0) check("R3", "segment word addr", {16'd0, rd_addr[0]}, {16'd0, a0});
      if (e_reads > 1) check("R3", "page word addr", {16'd0, rd_addr[1]}, {16'd0, a1});
      @(negedge clk);
      check("R12", "single response", {31'd0, rsp_valid}, 32'd0);
      if (!e_fault) begin
         if (!probe) begin
            exp_ref[fn] = 1'b1;
            if (wr) exp_chg[fn] = 1'b1;
         end
         chk_rc(probe ? "R8" : "R7", fn);
      end else begin
         chk_rc("R9", (s + p) % 16);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int f = 0; f < 16; f++) begin
         exp_ref[f] = 1'b0; exp_chg[f] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      check("R13", "ready", {31'd0, req_ready}, 32'd1);
      check("R13", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R13", "mem_rd", {31'd0, mem_rd}, 32'd0);
      for (int f = 0; f < 16; f++) chk_rc("R13", f);

      // R1 narrow sweep with junk upper bits, every segment
      ctl_stl = 12'd15;
      for (int s = 0; s < 16; s++) begin
         for (int p = 0; p < 256; p += 15) begin
            do_req({8'(s * 37 + p), 4'(s), 8'(p), 12'((s * p * 13) & 32'hfff)},
                   p[0], 1'b0, (p % 3) == 0);
         end
      end

      // R2 wide sweep, segments past the length fault (R4)
      ctl_stl = 12'd40;
      for (int s = 0; s < 61; s++) begin
         do_req({12'(s), 8'd0, 12'h123}, 1'b1, 1'b1, 1'b0);
         do_req({12'(s), 8'd7, 12'hABC}, 1'b0, 1'b1, 1'b0);
         do_req({12'(s), 8'd100, 12'h001}, 1'b1, 1'b1, 1'b1);
      end

      // R4 short table in narrow mode
      ctl_stl = 12'd5;
      for (int s = 0; s < 16; s++) do_req({8'hFF, 4'(s), 8'd1, 12'h0F0}, 1'b0, 1'b0, 1'b0);

      // R10 clear every frame
      for (int f = 0; f < 16; f++) begin
         @(negedge clk);
         rc_sel = 4'(f); rc_clr = 1'b1;
         @(negedge clk);
         rc_clr = 1'b0;
         exp_ref[f] = 1'b0; exp_chg[f] = 1'b0;
         chk_rc("R10", f);
      end

      // R11 translation off, writes and a probe
      ctl_xoff = 1'b1;
      do_req(32'hDEAD_5123, 1'b1, 1'b0, 1'b0);
      do_req(32'h0000_A777, 1'b0, 1'b1, 1'b0);
      do_req(32'h1234_3FFF, 1'b1, 1'b0, 1'b1);

      // R10 clear and set on the same edge: frame 5 has chg set, read sets ref only
      @(negedge clk);
      req_va = 32'h0000_5010; req_write = 1'b0; req_probe = 1'b0; req_valid = 1'b1;
      rc_sel = 4'd5; rc_clr = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; rc_clr = 1'b0;
      check("R11", "xoff addr", {16'd0, rsp_addr}, 32'h5010);
      exp_ref[5] = 1'b1; exp_chg[5] = 1'b0;
      @(negedge clk);
      chk_rc("R10", 5);
      ctl_xoff = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule